// File: doc/BRIEF.md
# Per-flow two-rate three-color traffic meter

This block meters packets flow by flow. Each flow owns one record in an on-chip table. The record holds two token buckets, a commit bucket and an excess bucket, together with the flow's profile (one refill rate and one size limit per bucket) and the tick of its last update. A configuration port writes a flow's profile and starting levels. Each packet request names a flow and a length. For every request the block does the following as one read-modify-write of that flow's record:

- It reads the record.
- It credits each bucket with the elapsed ticks times that bucket's rate.
- It charges the packet to one bucket, or to none.
- It writes the record back.
- It reports the color and both new levels for a downstream marker or dropper.

Rates are fixed-point tokens per tick with `FRAC_W` fractional bits. Bucket levels are carried in the same fixed-point format. The time base is a free-running tick counter supplied from outside, and the elapsed time is taken modulo its width. The pipeline accepts one request per cycle. When two requests to the same flow arrive in consecutive cycles, the record just written is bypassed into the second request, so no update is lost.

Top module: `tricolor_flow_meter`

## Requirements
- R1: While reset is asserted and after it is released, `res_valid` stays low until a request has been accepted.
- R2: A configuration write loads the flow's rates and size limits. It sets each level to its initial token count (fractional bits zero) and sets the record's last-update tick to `now_tick` of that cycle.
- R3: Before the debit, each bucket gains (`now_tick` − last tick) × rate. A rate's low `FRAC_W` bits are fractional, so a rate of 3 credits 3/16 token per tick with the default `FRAC_W`=4.
- R4: After credit, a bucket level never exceeds its size limit. Any credit beyond the limit is discarded.
- R5: If the credited commit level is at least the packet length, the color is green (code 0). The length is debited from the commit bucket only.
- R6: If the commit level is short and the credited excess level is at least the length, the color is yellow (code 1). The length is debited from the excess bucket only.
- R7: If neither bucket holds the length, the color is red (code 2). Both levels are reported and stored at their credited values, with no debit.
- R8: A request presented in cycle n yields `res_valid` and its results in cycle n+2, and not in cycle n+1 (default `OUT_REG`=1).
- R9: Two requests to the same flow in consecutive cycles are metered in order. The second one sees the levels and tick left by the first.
- R10: The elapsed time is computed modulo 2^`TS_W`, so it remains correct when `now_tick` wraps.
- R11: A request to one flow leaves every other flow's record unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| now_tick | input | TS_W | Free-running tick count |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_flow | input | FLOW_W | Flow being configured |
| cfg_commit_rate | input | RATE_W | Commit refill rate, fixed point |
| cfg_excess_rate | input | RATE_W | Excess refill rate, fixed point |
| cfg_commit_size | input | TOK_W | Commit bucket limit in tokens |
| cfg_excess_size | input | TOK_W | Excess bucket limit in tokens |
| cfg_commit_init | input | TOK_W | Starting commit level in tokens |
| cfg_excess_init | input | TOK_W | Starting excess level in tokens |
| req_valid | input | 1 | Packet request strobe |
| req_flow | input | FLOW_W | Flow of the packet |
| req_len | input | LEN_W | Packet length in tokens |
| res_valid | output | 1 | Result strobe |
| res_color | output | 2 | 0 green, 1 yellow, 2 red |
| res_commit_lvl | output | TOK_W+FRAC_W | Commit level after update, fixed point |
| res_excess_lvl | output | TOK_W+FRAC_W | Excess level after update, fixed point |

## Verification
The bench builds the block with its default parameters: 16 flows, a 16-bit tick, 4 fractional bits, 18-bit token limits and a registered output. The 16-bit tick allows a wrap to be set up with a configuration write at tick 65530 followed by a request at tick 4. The 4 fractional bits make a sub-token rate such as 3/16 observable after a few ticks. Limits of a few hundred tokens are reached within a few thousand ticks, so saturation is exercised. Consecutive requests to one flow are arranged so that a missing bypass would turn a yellow result into a green one.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
   typedef enum logic [1:0] {
      TC_GREEN  = 2'd0,
      TC_YELLOW = 2'd1,
      TC_RED    = 2'd2
   } tc_color_e;
endpackage

// File: rtl/tcm_record_ram.sv
module tcm_record_ram #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 128,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data
);
   logic [WIDTH-1:0] mem [DEPTH];

   // Read returns the contents from before a same-edge write.
   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      if (rd_en) rd_data <= mem[rd_addr];
   end
endmodule

// File: rtl/tcm_credit.sv
module tcm_credit #(
   parameter int TOK_W  = 18,
   parameter int FRAC_W = 4,
   parameter int RATE_W = 16,
   parameter int TS_W   = 16,
   localparam int LW    = TOK_W + FRAC_W,
   localparam int PW    = TS_W + RATE_W,
   localparam int SW    = ((PW > LW) ? PW : LW) + 1
) (
   input  logic [LW-1:0]     level,
   input  logic [RATE_W-1:0] rate,
   input  logic [TOK_W-1:0]  size,
   input  logic [TS_W-1:0]   elapsed,
   output logic [LW-1:0]     credited
);
   logic [PW-1:0] earned;
   logic [SW-1:0] sum;
   logic [SW-1:0] cap;

   always_comb begin
      earned   = PW'(elapsed) * PW'(rate);
      sum      = SW'(level) + SW'(earned);
      cap      = SW'({size, {FRAC_W{1'b0}}});
      credited = (sum > cap) ? LW'(cap) : LW'(sum);
   end
endmodule

// File: rtl/tricolor_flow_meter.sv
module tricolor_flow_meter
   import tcm_pkg::*;
#(
   parameter int FLOWS   = 16,
   parameter int TOK_W   = 18,
   parameter int FRAC_W  = 4,
   parameter int RATE_W  = 16,
   parameter int TS_W    = 16,
   parameter int LEN_W   = 14,
   parameter bit OUT_REG = 1'b1,
   localparam int FLOW_W = $clog2(FLOWS),
   localparam int LW     = TOK_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TS_W-1:0]   now_tick,
   input  logic              cfg_we,
   input  logic [FLOW_W-1:0] cfg_flow,
   input  logic [RATE_W-1:0] cfg_commit_rate,
   input  logic [RATE_W-1:0] cfg_excess_rate,
   input  logic [TOK_W-1:0]  cfg_commit_size,
   input  logic [TOK_W-1:0]  cfg_excess_size,
   input  logic [TOK_W-1:0]  cfg_commit_init,
   input  logic [TOK_W-1:0]  cfg_excess_init,
   input  logic              req_valid,
   input  logic [FLOW_W-1:0] req_flow,
   input  logic [LEN_W-1:0]  req_len,
   output logic              res_valid,
   output logic [1:0]        res_color,
   output logic [LW-1:0]     res_commit_lvl,
   output logic [LW-1:0]     res_excess_lvl
);
   localparam int REC_W = TS_W + 2*TOK_W + 2*RATE_W + 2*LW;

   // Elaboration-time parameter checks
   if (FLOWS < 2 || (1 << FLOW_W) != FLOWS) begin : g_chk_flows
      $error("FLOWS must be a power of two of at least 2");
   end
   if (LEN_W > TOK_W) begin : g_chk_len
      $error("LEN_W must not exceed TOK_W");
   end
   if (FRAC_W < 1 || FRAC_W >= RATE_W) begin : g_chk_frac
      $error("FRAC_W must lie in 1..RATE_W-1");
   end

   // Record table
   logic              wr_en;
   logic [FLOW_W-1:0] wr_addr;
   logic [REC_W-1:0]  wr_data;
   logic [REC_W-1:0]  ram_q;
   logic [REC_W-1:0]  cfg_rec;
   logic [REC_W-1:0]  wb_rec;

   // Stage 1: record available, credit and debit
   logic              s1_valid;
   logic [FLOW_W-1:0] s1_flow;
   logic [LEN_W-1:0]  s1_len;
   logic [TS_W-1:0]   s1_now;
   logic              s1_byp;
   logic [REC_W-1:0]  s1_byp_rec;
   logic [REC_W-1:0]  s1_rec;

   assign cfg_rec = {now_tick, cfg_excess_size, cfg_commit_size,
                     cfg_excess_rate, cfg_commit_rate,
                     cfg_excess_init, {FRAC_W{1'b0}},
                     cfg_commit_init, {FRAC_W{1'b0}}};

   // A configuration write takes the port over a write-back.
   assign wr_en   = cfg_we | s1_valid;
   assign wr_addr = cfg_we ? cfg_flow : s1_flow;
   assign wr_data = cfg_we ? cfg_rec : wb_rec;

   tcm_record_ram #(.DEPTH(FLOWS), .WIDTH(REC_W)) u_table (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (req_valid),
      .rd_addr (req_flow),
      .rd_data (ram_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s1_valid <= 1'b0;
      else        s1_valid <= req_valid;
   end

   always_ff @(posedge clk) begin
      if (req_valid) begin
         s1_flow    <= req_flow;
         s1_len     <= req_len;
         s1_now     <= now_tick;
         s1_byp     <= (cfg_we && cfg_flow == req_flow) ||
                       (s1_valid && s1_flow == req_flow);
         s1_byp_rec <= (cfg_we && cfg_flow == req_flow) ? cfg_rec : wb_rec;
      end
   end

   assign s1_rec = s1_byp ? s1_byp_rec : ram_q;

   // Record fields
   logic [TS_W-1:0]   r_ts;
   logic [TOK_W-1:0]  r_csz, r_esz;
   logic [RATE_W-1:0] r_crate, r_erate;
   logic [LW-1:0]     r_clvl, r_elvl;

   assign {r_ts, r_esz, r_csz, r_erate, r_crate, r_elvl, r_clvl} = s1_rec;

   logic [TS_W-1:0]   elapsed;
   logic [LW-1:0]     lvl_in [2];
   logic [RATE_W-1:0] rate_in [2];
   logic [TOK_W-1:0]  size_in [2];
   logic [LW-1:0]     cred [2];

   assign elapsed    = s1_now - r_ts;
   assign lvl_in[0]  = r_clvl;
   assign lvl_in[1]  = r_elvl;
   assign rate_in[0] = r_crate;
   assign rate_in[1] = r_erate;
   assign size_in[0] = r_csz;
   assign size_in[1] = r_esz;

   for (genvar b = 0; b < 2; b++) begin : g_bucket
      tcm_credit #(.TOK_W(TOK_W), .FRAC_W(FRAC_W), .RATE_W(RATE_W), .TS_W(TS_W))
         u_credit (
            .level    (lvl_in[b]),
            .rate     (rate_in[b]),
            .size     (size_in[b]),
            .elapsed  (elapsed),
            .credited (cred[b])
         );
   end

   // Debit: all from commit, else all from excess, else none
   logic [LW-1:0] len_fx;
   logic [LW-1:0] new_c, new_e;
   tc_color_e     s1_color;

   always_comb begin
      len_fx = LW'({s1_len, {FRAC_W{1'b0}}});
      new_c  = cred[0];
      new_e  = cred[1];
      if (cred[0] >= len_fx) begin
         s1_color = TC_GREEN;
         new_c    = cred[0] - len_fx;
      end else if (cred[1] >= len_fx) begin
         s1_color = TC_YELLOW;
         new_e    = cred[1] - len_fx;
      end else begin
         s1_color = TC_RED;
      end
   end

   assign wb_rec = {s1_now, r_esz, r_csz, r_erate, r_crate, new_e, new_c};

   AST_ONE_BUCKET: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |-> (new_c == cred[0]) || (new_e == cred[1]))
      else $error("both buckets debited");                           // R5
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |-> (new_c <= cred[0]) && (new_e <= cred[1]))
      else $error("debit raised a level");                          // R6
   AST_RED_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid && s1_color == TC_RED |-> new_c == cred[0] && new_e == cred[1])
      else $error("red packet debited");                            // R7
   AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |-> new_c <= LW'({r_csz, {FRAC_W{1'b0}}}) &&
                   new_e <= LW'({r_esz, {FRAC_W{1'b0}}}))
      else $error("level above limit");                             // R4

   // Output stage variant
   if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) res_valid <= 1'b0;
         else        res_valid <= s1_valid;
      end
      always_ff @(posedge clk) begin
         if (s1_valid) begin
            res_color      <= s1_color;
            res_commit_lvl <= new_c;
            res_excess_lvl <= new_e;
         end
      end
      AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> ##1 res_valid)
         else $error("result missing two cycles after request");    // R8
   end else begin : g_ocomb
      assign res_valid      = s1_valid;
      assign res_color      = s1_color;
      assign res_commit_lvl = new_c;
      assign res_excess_lvl = new_e;
      AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> res_valid)
         else $error("result missing one cycle after request");     // R8
   end

   AST_COLOR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_color != 2'b11)
      else $error("illegal color code");                            // R5
endmodule

// File: tb/tricolor_flow_meter_tb_top.sv
`timescale 1ns/1ps
module tricolor_flow_meter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] now_tick = '0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_flow = '0;
   logic [15:0] cfg_commit_rate = '0, cfg_excess_rate = '0;
   logic [17:0] cfg_commit_size = '0, cfg_excess_size = '0;
   logic [17:0] cfg_commit_init = '0, cfg_excess_init = '0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_flow = '0;
   logic [13:0] req_len = '0;
   logic        res_valid;
   logic [1:0]  res_color;
   logic [21:0] res_commit_lvl, res_excess_lvl;

   int checks = 0;
   int errors = 0;

   // Reference state per flow (fixed point, 4 fractional bits)
   longint m_c [16], m_e [16], m_cr [16], m_er [16], m_cs [16], m_es [16], m_ts [16];

   always #2 clk = ~clk;

   tricolor_flow_meter dut_i (
      .clk(clk), .rst_n(rst_n), .now_tick(now_tick),
      .cfg_we(cfg_we), .cfg_flow(cfg_flow),
      .cfg_commit_rate(cfg_commit_rate), .cfg_excess_rate(cfg_excess_rate),
      .cfg_commit_size(cfg_commit_size), .cfg_excess_size(cfg_excess_size),
      .cfg_commit_init(cfg_commit_init), .cfg_excess_init(cfg_excess_init),
      .req_valid(req_valid), .req_flow(req_flow), .req_len(req_len),
      .res_valid(res_valid), .res_color(res_color),
      .res_commit_lvl(res_commit_lvl), .res_excess_lvl(res_excess_lvl)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model(input int f, input int len, input int t,
                        output int col, output longint c, output longint e);
      longint el;
      el = (t - m_ts[f]) & 16'hFFFF;
      c = m_c[f] + el * m_cr[f];
      e = m_e[f] + el * m_er[f];
      if (c > m_cs[f] * 16) c = m_cs[f] * 16;
      if (e > m_es[f] * 16) e = m_es[f] * 16;
      if (c >= len * 16)      begin col = 0; c = c - len * 16; end
      else if (e >= len * 16) begin col = 1; e = e - len * 16; end
      else                    col = 2;
      m_c[f] = c; m_e[f] = e; m_ts[f] = t;
   endtask

   task automatic configure(input int f, input int cr, input int er, input int cs,
                            input int es, input int ci, input int ei, input int t);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_flow = 4'(f); now_tick = 16'(t);
      cfg_commit_rate = 16'(cr); cfg_excess_rate = 16'(er);
      cfg_commit_size = 18'(cs); cfg_excess_size = 18'(es);
      cfg_commit_init = 18'(ci); cfg_excess_init = 18'(ei);
      m_cr[f] = cr; m_er[f] = er; m_cs[f] = cs; m_es[f] = es;
      m_c[f] = longint'(ci) * 16; m_e[f] = longint'(ei) * 16; m_ts[f] = t;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic compare(input string tag, input int col, input longint c, input longint e);
      check(res_valid == 1'b1, {tag, " valid"}, res_valid, 1);
      check(res_color == 2'(col), {tag, " color"}, res_color, col);
      check(res_commit_lvl == 22'(c), {tag, " commit"}, res_commit_lvl, c);
      check(res_excess_lvl == 22'(e), {tag, " excess"}, res_excess_lvl, e);
   endtask

   // Single request; checks the R8 timing and the result
   task automatic meter_one(input int f, input int len, input int t, input string tag);
      int col; longint c, e;
      @(posedge clk); #1;
      req_valid = 1'b1; req_flow = 4'(f); req_len = 14'(len); now_tick = 16'(t);
      model(f, len, t, col, c, e);
      @(posedge clk); #1;
      req_valid = 1'b0;
      @(negedge clk);
      check(res_valid == 1'b0, "R8 early", res_valid, 0);
      @(posedge clk); @(negedge clk);
      compare(tag, col, c, e);
   endtask

   task automatic test_reset();
      @(negedge clk);
      check(res_valid == 1'b0, "R1 in reset", res_valid, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(res_valid == 1'b0, "R1 after reset", res_valid, 0);
   endtask

   task automatic test_colors();
      configure(3, 16, 8, 1000, 500, 100, 50, 0);
      meter_one(3, 60, 0, "R2 R5 green from init");
      meter_one(3, 80, 10, "R7 red");
      meter_one(3, 60, 20, "R5 green");
      meter_one(3, 55, 30, "R6 yellow");
   endtask

   task automatic test_saturation();
      meter_one(3, 1, 5000, "R4 saturate");
   endtask

   task automatic test_fraction();
      configure(5, 3, 0, 100, 100, 0, 0, 100);
      meter_one(5, 1, 107, "R3 fractional credit");
   endtask

   task automatic test_isolation();
      meter_one(5, 2, 200, "R11 other flow");
      meter_one(3, 0, 5000, "R11 flow untouched");
   endtask

   task automatic test_back_to_back();
      int col_a, col_b; longint ca, ea, cb, eb;
      @(posedge clk); #1;
      req_valid = 1'b1; req_flow = 4'd3; req_len = 14'd900; now_tick = 16'd5001;
      model(3, 900, 5001, col_a, ca, ea);
      @(posedge clk); #1;
      req_len = 14'd400; now_tick = 16'd5002;
      model(3, 400, 5002, col_b, cb, eb);
      @(posedge clk); #1;
      req_valid = 1'b0;
      @(negedge clk);
      compare("R9 first", col_a, ca, ea);
      @(posedge clk); @(negedge clk);
      compare("R9 second", col_b, cb, eb);
   endtask

   task automatic test_wrap();
      configure(7, 16, 16, 50, 50, 0, 0, 65530);
      meter_one(7, 5, 4, "R10 tick wrap");
      meter_one(7, 200, 6, "R7 red after wrap");
   endtask

   initial begin
      test_reset();
      test_colors();
      test_saturation();
      test_fraction();
      test_isolation();
      test_back_to_back();
      test_wrap();
      repeat (4) @(posedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule